// File: doc/BRIEF.md
# Two-Bank Indirect Configuration Register Port

This block holds the configuration of two disk-interface channels. Software cannot address the registers directly. It writes a pointer byte that names a channel bank and a register index, and then reads or writes that register through a 16-bit data port. The pointer byte also carries three bus-timing options that apply to the whole device.

Each bank holds seven registers: a command-block base address, a general configuration byte, the two halves of a read-ahead setup, a control-block base address, and two timing bytes. When the pointer's auto-step bit is set, the index advances after every data-port access, so a whole bank can be loaded with a burst of writes. The registers drive plain output pins that the channel logic decodes.

Requests enter on a valid/ready channel. Reads return on a second valid/ready channel that holds one entry. The request side stalls while an unconsumed read result is waiting, which is how back-pressure from the reader reaches the requester. Writes produce no response.

Top module: `cfgport_top`

## Requirements
- R1: After reset, bank 0 reads command base 0x01F0 and control base 0x03F6, and bank 1 reads 0x0170 and 0x0376. Both banks read data timing 0xF5, command timing 0xDE, general configuration 0x01 and read-ahead count 0. The pointer reads 0x50, so posted_wait_o=1, burst_dis_o=0 and devsel_med_o=1.
- R2: A write with req_sel=0 loads the pointer from req_wdata[7:0]. In the pointer, bit7 is auto-step, bit6 drives posted_wait_o, bit5 drives burst_dis_o, bit4 drives devsel_med_o, bit3 selects the bank and bits 2:0 are the index. A pointer read returns the pointer with bit5 forced to 0, zero-extended to 16 bits.
- R3: Data-port writes (req_sel=1) change only the bank selected by the pointer. Index 0 (command base) and index 4 (control base) take all 16 bits. Index 5 (data timing) and index 6 (command timing) take req_wdata[7:0]. Reads of these registers return the stored value, zero-extended.
- R4: Index 1 stores bits 7, 6, 5, 4, 3, 1 and 0 of the written byte and drives gen_cfg_o. Bit 2 is never stored and always reads as 0.
- R5: Index 2 loads read-ahead count bits 7:0. Index 3 loads count bits 9:8 from bits 1:0, read-ahead enable from bit7 and mode-4 timing from bit4. Reads of index 2 and index 3 return 0.
- R6: A write to index 3 with bit6 set raises fifo_clr_o for that bank for exactly the one cycle after the write. The bit is not stored.
- R7: When pointer bit7 is set, each accepted data-port access to index 0 to 5 advances the index by one, and an access to index 6 wraps the index to 0. When bit7 is clear, the index does not change.
- R8: At index 7, data writes change nothing, data reads return 0 and the index does not advance.
- R9: A request is taken on a cycle where req_valid and req_ready are both high. A read result appears on rsp_valid in the next cycle and is held with stable data until rsp_ready is high. req_ready is low only while a result is waiting and rsp_ready is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Request can be taken |
| req_sel | input | 1 | 0 = pointer byte, 1 = data port |
| req_write | input | 1 | 1 = write, 0 = read |
| req_wdata | input | 16 | Write data |
| rsp_valid | output | 1 | Read result present |
| rsp_ready | input | 1 | Read result consumed |
| rsp_rdata | output | 16 | Read result |
| cmd_base_o | output | 32 | Command-block base, bank b at [16b+15:16b] |
| ctl_base_o | output | 32 | Control-block base, bank b at [16b+15:16b] |
| gen_cfg_o | output | 16 | General configuration byte per bank |
| ra_count_o | output | 20 | 10-bit read-ahead count per bank |
| ra_enable_o | output | 2 | Read-ahead enable per bank |
| ra_mode4_o | output | 2 | Mode-4 timing enable per bank |
| fifo_clr_o | output | 2 | One-cycle FIFO clear pulse per bank |
| data_tim_o | output | 16 | Data-port timing byte per bank |
| cmd_tim_o | output | 16 | Command-port timing byte per bank |
| posted_wait_o | output | 1 | Posted-write wait state select |
| burst_dis_o | output | 1 | Master burst disable |
| devsel_med_o | output | 1 | Medium select-timing select |

## Verification
The hardest state to reach from the ports is a request that arrives while a read result is stalled. That request must stay untaken until the result drains, and it must then land exactly once. The bench stops consuming results, offers a pointer write during the stall, and checks both the held response and the unchanged pointer outputs before it releases the stall. Index 7 and the 6-to-0 wrap are also rare under random pointers. Directed bursts with auto-step enabled sweep a full bank, and the pointer is read back so the bench can see the index directly.

// File: rtl/cfgport_pkg.sv
package cfgport_pkg;
  localparam int NBANK  = 2;
  localparam int BASE_W = 16;
  localparam int BYTE_W = 8;
  localparam int RA_W   = 10;
  localparam int IDX_W  = 3;
  localparam int RA_HI_W = RA_W - BYTE_W;

  localparam logic [IDX_W-1:0] IX_CMD  = 3'd0;
  localparam logic [IDX_W-1:0] IX_GEN  = 3'd1;
  localparam logic [IDX_W-1:0] IX_RAL  = 3'd2;
  localparam logic [IDX_W-1:0] IX_RAH  = 3'd3;
  localparam logic [IDX_W-1:0] IX_CTL  = 3'd4;
  localparam logic [IDX_W-1:0] IX_DTM  = 3'd5;
  localparam logic [IDX_W-1:0] IX_CTM  = 3'd6;
  localparam logic [IDX_W-1:0] IX_LAST = IX_CTM;
  localparam logic [IDX_W-1:0] IX_VOID = 3'd7;

  localparam int P_AINC    = 7;
  localparam int P_WAIT    = 6;
  localparam int P_NOBURST = 5;
  localparam int P_DEVSEL  = 4;
  localparam int P_BANK    = 3;

  localparam logic [BYTE_W-1:0] PTR_RST     = 8'h50;
  localparam logic [BYTE_W-1:0] PTR_RD_MASK = 8'hDF;
  localparam logic [BYTE_W-1:0] GEN_MASK    = 8'hFB;
  localparam logic [BYTE_W-1:0] GEN_RST     = 8'h01;
  localparam logic [BYTE_W-1:0] DTM_RST     = 8'hF5;
  localparam logic [BYTE_W-1:0] CTM_RST     = 8'hDE;

  localparam int RAH_EN_BIT  = 7;
  localparam int RAH_CLR_BIT = 6;
  localparam int RAH_M4_BIT  = 4;

  typedef struct packed {
    logic [BASE_W-1:0] cmd_base;
    logic [BASE_W-1:0] ctl_base;
    logic [BYTE_W-1:0] gen;
    logic [RA_W-1:0]   ra_cnt;
    logic              ra_en;
    logic              mode4;
    logic [BYTE_W-1:0] dtm;
    logic [BYTE_W-1:0] ctm;
  } bank_cfg_t;

  function automatic logic [BASE_W-1:0] cmd_base_rst(input int b);
    return (b == 0) ? 16'h01F0 : 16'h0170;
  endfunction

  function automatic logic [BASE_W-1:0] ctl_base_rst(input int b);
    return (b == 0) ? 16'h03F6 : 16'h0376;
  endfunction

  function automatic logic [IDX_W-1:0] idx_step(input logic [IDX_W-1:0] i);
    return (i == IX_LAST) ? '0 : i + 1'b1;
  endfunction
endpackage

// File: rtl/cfgport_ptr.sv
module cfgport_ptr
  import cfgport_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ptr_wr,
  input  logic [BYTE_W-1:0] ptr_wdata,
  input  logic              data_acc,
  output logic [BYTE_W-1:0] ptr_q
);
  logic [IDX_W-1:0] idx_next;

  assign idx_next = idx_step(ptr_q[IDX_W-1:0]);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ptr_q <= PTR_RST;
    end else if (ptr_wr) begin
      ptr_q <= ptr_wdata;
    end else if (data_acc && ptr_q[P_AINC]) begin
      ptr_q[IDX_W-1:0] <= idx_next;
    end
  end
endmodule

// File: rtl/cfgport_bank.sv
module cfgport_bank
  import cfgport_pkg::*;
#(
  parameter int BANK_ID = 0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [IDX_W-1:0]  idx,
  input  logic [BASE_W-1:0] wdata,
  output bank_cfg_t         cfg,
  output logic              fifo_clr,
  output logic [BASE_W-1:0] rdata
);
  localparam logic [BASE_W-1:0] CMD_RST = cmd_base_rst(BANK_ID);
  localparam logic [BASE_W-1:0] CTL_RST = ctl_base_rst(BANK_ID);

  logic [BYTE_W-1:0] wbyte;
  assign wbyte = wdata[BYTE_W-1:0];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cfg.cmd_base <= CMD_RST;
      cfg.ctl_base <= CTL_RST;
      cfg.gen      <= GEN_RST;
      cfg.ra_cnt   <= '0;
      cfg.ra_en    <= 1'b0;
      cfg.mode4    <= 1'b0;
      cfg.dtm      <= DTM_RST;
      cfg.ctm      <= CTM_RST;
    end else if (wr_en) begin
      case (idx)
        IX_CMD: cfg.cmd_base <= wdata;
        IX_GEN: cfg.gen <= wbyte & GEN_MASK;
        IX_RAL: cfg.ra_cnt[BYTE_W-1:0] <= wbyte;
        IX_RAH: begin
          cfg.ra_cnt[RA_W-1:BYTE_W] <= wbyte[RA_HI_W-1:0];
          cfg.ra_en <= wbyte[RAH_EN_BIT];
          cfg.mode4 <= wbyte[RAH_M4_BIT];
        end
        IX_CTL: cfg.ctl_base <= wdata;
        IX_DTM: cfg.dtm <= wbyte;
        IX_CTM: cfg.ctm <= wbyte;
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) fifo_clr <= 1'b0;
    else        fifo_clr <= wr_en && (idx == IX_RAH) && wbyte[RAH_CLR_BIT];
  end

  always_comb begin
    rdata = '0;
    case (idx)
      IX_CMD: rdata = cfg.cmd_base;
      IX_GEN: rdata = {{(BASE_W-BYTE_W){1'b0}}, cfg.gen};
      IX_CTL: rdata = cfg.ctl_base;
      IX_DTM: rdata = {{(BASE_W-BYTE_W){1'b0}}, cfg.dtm};
      IX_CTM: rdata = {{(BASE_W-BYTE_W){1'b0}}, cfg.ctm};
      default: rdata = '0;
    endcase
  end
endmodule

// File: rtl/cfgport_rsp.sv
module cfgport_rsp #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load,
  input  logic [W-1:0] load_data,
  output logic         rsp_valid,
  input  logic         rsp_ready,
  output logic [W-1:0] rsp_rdata,
  output logic         can_take
);
  assign can_take = !rsp_valid || rsp_ready;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rsp_valid <= 1'b0;
      rsp_rdata <= '0;
    end else if (load) begin
      rsp_valid <= 1'b1;
      rsp_rdata <= load_data;
    end else if (rsp_ready) begin
      rsp_valid <= 1'b0;
    end
  end
endmodule

// File: rtl/cfgport_top.sv
module cfgport_top
  import cfgport_pkg::*;
(
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     req_valid,
  output logic                     req_ready,
  input  logic                     req_sel,
  input  logic                     req_write,
  input  logic [BASE_W-1:0]        req_wdata,
  output logic                     rsp_valid,
  input  logic                     rsp_ready,
  output logic [BASE_W-1:0]        rsp_rdata,
  output logic [NBANK*BASE_W-1:0]  cmd_base_o,
  output logic [NBANK*BASE_W-1:0]  ctl_base_o,
  output logic [NBANK*BYTE_W-1:0]  gen_cfg_o,
  output logic [NBANK*RA_W-1:0]    ra_count_o,
  output logic [NBANK-1:0]         ra_enable_o,
  output logic [NBANK-1:0]         ra_mode4_o,
  output logic [NBANK-1:0]         fifo_clr_o,
  output logic [NBANK*BYTE_W-1:0]  data_tim_o,
  output logic [NBANK*BYTE_W-1:0]  cmd_tim_o,
  output logic                     posted_wait_o,
  output logic                     burst_dis_o,
  output logic                     devsel_med_o
);
  logic              take;
  logic              ptr_wr;
  logic              data_acc;
  logic              rd_take;
  logic [BYTE_W-1:0] ptr_q;
  logic [IDX_W-1:0]  cur_idx;
  logic              cur_bank;
  logic [BASE_W-1:0] bank_rdata [NBANK];
  logic [BASE_W-1:0] rd_mux;

  assign take     = req_valid && req_ready;
  assign cur_idx  = ptr_q[IDX_W-1:0];
  assign cur_bank = ptr_q[P_BANK];
  assign ptr_wr   = take && req_write && !req_sel;
  assign data_acc = take && req_sel && (cur_idx != IX_VOID);
  assign rd_take  = take && !req_write;

  cfgport_ptr u_ptr (
    .clk      (clk),
    .rst_n    (rst_n),
    .ptr_wr   (ptr_wr),
    .ptr_wdata(req_wdata[BYTE_W-1:0]),
    .data_acc (data_acc),
    .ptr_q    (ptr_q)
  );

  assign posted_wait_o = ptr_q[P_WAIT];
  assign burst_dis_o   = ptr_q[P_NOBURST];
  assign devsel_med_o  = ptr_q[P_DEVSEL];

  for (genvar b = 0; b < NBANK; b++) begin : g_bank
    bank_cfg_t cfg;
    logic      wr_en;
    logic      clr;

    assign wr_en = data_acc && req_write && (cur_bank == b[0]);

    cfgport_bank #(.BANK_ID(b)) u_bank (
      .clk     (clk),
      .rst_n   (rst_n),
      .wr_en   (wr_en),
      .idx     (cur_idx),
      .wdata   (req_wdata),
      .cfg     (cfg),
      .fifo_clr(clr),
      .rdata   (bank_rdata[b])
    );

    assign cmd_base_o[b*BASE_W +: BASE_W] = cfg.cmd_base;
    assign ctl_base_o[b*BASE_W +: BASE_W] = cfg.ctl_base;
    assign gen_cfg_o[b*BYTE_W +: BYTE_W]  = cfg.gen;
    assign ra_count_o[b*RA_W +: RA_W]     = cfg.ra_cnt;
    assign ra_enable_o[b]                 = cfg.ra_en;
    assign ra_mode4_o[b]                  = cfg.mode4;
    assign fifo_clr_o[b]                  = clr;
    assign data_tim_o[b*BYTE_W +: BYTE_W] = cfg.dtm;
    assign cmd_tim_o[b*BYTE_W +: BYTE_W]  = cfg.ctm;
  end

  always_comb begin
    if (!req_sel) rd_mux = {{(BASE_W-BYTE_W){1'b0}}, ptr_q & PTR_RD_MASK};
    else          rd_mux = bank_rdata[cur_bank];
  end

  cfgport_rsp #(.W(BASE_W)) u_rsp (
    .clk      (clk),
    .rst_n    (rst_n),
    .load     (rd_take),
    .load_data(rd_mux),
    .rsp_valid(rsp_valid),
    .rsp_ready(rsp_ready),
    .rsp_rdata(rsp_rdata),
    .can_take (req_ready)
  );
endmodule

// File: rtl/cfgport_sva.sv
module cfgport_sva
  import cfgport_pkg::*;
(
  input logic              clk,
  input logic              rst_n,
  input logic              req_valid,
  input logic              req_ready,
  input logic              req_sel,
  input logic              req_write,
  input logic [BASE_W-1:0] req_wdata,
  input logic              rsp_valid,
  input logic              rsp_ready,
  input logic [BASE_W-1:0] rsp_rdata,
  input logic [NBANK-1:0]  fifo_clr_o,
  input logic [BYTE_W-1:0] ptr_q,
  input logic              posted_wait_o,
  input logic              devsel_med_o
);
  // R9: an unconsumed result is held steady
  a_r9_rsp_hold: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid && !rsp_ready |=> rsp_valid && $stable(rsp_rdata));

  // R9: a taken read yields a result in the next cycle
  a_r9_read_resp: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid && req_ready && !req_write |=> rsp_valid);

  // R2: pointer write reaches the global option pins
  a_r2_ptr_opts: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid && req_ready && req_write && !req_sel |=>
      posted_wait_o == $past(req_wdata[P_WAIT]) && devsel_med_o == $past(req_wdata[P_DEVSEL]));

  // R7: auto-step wraps from the last index to zero
  a_r7_wrap: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid && req_ready && req_sel && ptr_q[P_AINC] && ptr_q[IDX_W-1:0] == IX_LAST
      |=> ptr_q[IDX_W-1:0] == '0);

  // R8: the void index never steps
  a_r8_void_hold: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid && req_ready && req_sel && ptr_q[IDX_W-1:0] == IX_VOID
      |=> ptr_q[IDX_W-1:0] == IX_VOID);

  // R6: a clear pulse only follows a taken data write
  for (genvar b = 0; b < NBANK; b++) begin : g_clr
    a_r6_clr_cause: assert property (@(posedge clk) disable iff (!rst_n)
      fifo_clr_o[b] |-> $past(req_valid && req_ready && req_write && req_sel));
  end
endmodule

bind cfgport_top cfgport_sva u_sva (
  .clk          (clk),
  .rst_n        (rst_n),
  .req_valid    (req_valid),
  .req_ready    (req_ready),
  .req_sel      (req_sel),
  .req_write    (req_write),
  .req_wdata    (req_wdata),
  .rsp_valid    (rsp_valid),
  .rsp_ready    (rsp_ready),
  .rsp_rdata    (rsp_rdata),
  .fifo_clr_o   (fifo_clr_o),
  .ptr_q        (ptr_q),
  .posted_wait_o(posted_wait_o),
  .devsel_med_o (devsel_med_o)
);

// File: tb/tb_cfgport_top.sv
module tb_cfgport_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0;
  logic        req_ready;
  logic        req_sel = 1'b0;
  logic        req_write = 1'b0;
  logic [15:0] req_wdata = '0;
  logic        rsp_valid;
  logic        rsp_ready = 1'b1;
  logic [15:0] rsp_rdata;
  logic [31:0] cmd_base_o, ctl_base_o;
  logic [15:0] gen_cfg_o, data_tim_o, cmd_tim_o;
  logic [19:0] ra_count_o;
  logic [1:0]  ra_enable_o, ra_mode4_o, fifo_clr_o;
  logic        posted_wait_o, burst_dis_o, devsel_med_o;

  always #2 clk = ~clk;

  cfgport_top dut (.*);

  int checks = 0;
  int fails  = 0;

  logic [7:0]  m_ptr;
  logic [15:0] m_cmd [2];
  logic [15:0] m_ctl [2];
  logic [7:0]  m_gen [2];
  logic [9:0]  m_ra  [2];
  logic        m_en  [2];
  logic        m_m4  [2];
  logic [7:0]  m_dt  [2];
  logic [7:0]  m_ct  [2];
  logic        m_clr [2];

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic model_reset();
    m_ptr = 8'h50;
    for (int b = 0; b < 2; b++) begin
      m_cmd[b] = (b == 0) ? 16'h01F0 : 16'h0170;
      m_ctl[b] = (b == 0) ? 16'h03F6 : 16'h0376;
      m_gen[b] = 8'h01; m_ra[b] = '0; m_en[b] = 0; m_m4[b] = 0;
      m_dt[b] = 8'hF5; m_ct[b] = 8'hDE; m_clr[b] = 0;
    end
  endtask

  function automatic logic [15:0] exp_rd(input bit sel);
    int b = m_ptr[3];
    if (!sel) return {8'h00, m_ptr & 8'hDF};
    case (m_ptr[2:0])
      3'd0: return m_cmd[b];
      3'd1: return {8'h00, m_gen[b]};
      3'd4: return m_ctl[b];
      3'd5: return {8'h00, m_dt[b]};
      3'd6: return {8'h00, m_ct[b]};
      default: return 16'h0000;
    endcase
  endfunction

  function automatic string rd_tag(input bit sel, input logic [2:0] i);
    if (!sel) return "R2";
    case (i)
      3'd1: return "R4";
      3'd2, 3'd3: return "R5";
      3'd7: return "R8";
      default: return "R3";
    endcase
  endfunction

  task automatic model_apply(input bit sel, input bit wr, input logic [15:0] d);
    int b = m_ptr[3];
    logic [2:0] i = m_ptr[2:0];
    m_clr[0] = 0; m_clr[1] = 0;
    if (!sel) begin
      if (wr) m_ptr = d[7:0];
      return;
    end
    if (i == 3'd7) return;
    if (wr) begin
      case (i)
        3'd0: m_cmd[b] = d;
        3'd1: m_gen[b] = d[7:0] & 8'hFB;
        3'd2: m_ra[b][7:0] = d[7:0];
        3'd3: begin m_ra[b][9:8] = d[1:0]; m_en[b] = d[7]; m_m4[b] = d[4]; m_clr[b] = d[6]; end
        3'd4: m_ctl[b] = d;
        3'd5: m_dt[b] = d[7:0];
        3'd6: m_ct[b] = d[7:0];
        default: ;
      endcase
    end
    if (m_ptr[7]) m_ptr[2:0] = (i == 3'd6) ? 3'd0 : i + 3'd1;
  endtask

  task automatic check_all(input string tag);
    chk(posted_wait_o == m_ptr[6], "R2 posted_wait", posted_wait_o, m_ptr[6]);
    chk(burst_dis_o == m_ptr[5], "R2 burst_dis", burst_dis_o, m_ptr[5]);
    chk(devsel_med_o == m_ptr[4], "R2 devsel", devsel_med_o, m_ptr[4]);
    for (int b = 0; b < 2; b++) begin
      chk(cmd_base_o[b*16 +: 16] == m_cmd[b], {tag, " R3 cmd_base"}, cmd_base_o[b*16 +: 16], m_cmd[b]);
      chk(ctl_base_o[b*16 +: 16] == m_ctl[b], {tag, " R3 ctl_base"}, ctl_base_o[b*16 +: 16], m_ctl[b]);
      chk(gen_cfg_o[b*8 +: 8] == m_gen[b], {tag, " R4 gen_cfg"}, gen_cfg_o[b*8 +: 8], m_gen[b]);
      chk(ra_count_o[b*10 +: 10] == m_ra[b], {tag, " R5 ra_count"}, ra_count_o[b*10 +: 10], m_ra[b]);
      chk(ra_enable_o[b] == m_en[b], {tag, " R5 ra_enable"}, ra_enable_o[b], m_en[b]);
      chk(ra_mode4_o[b] == m_m4[b], {tag, " R5 mode4"}, ra_mode4_o[b], m_m4[b]);
      chk(data_tim_o[b*8 +: 8] == m_dt[b], {tag, " R3 data_tim"}, data_tim_o[b*8 +: 8], m_dt[b]);
      chk(cmd_tim_o[b*8 +: 8] == m_ct[b], {tag, " R3 cmd_tim"}, cmd_tim_o[b*8 +: 8], m_ct[b]);
      chk(fifo_clr_o[b] == m_clr[b], {tag, " R6 fifo_clr"}, fifo_clr_o[b], m_clr[b]);
    end
  endtask

  task automatic acc(input bit sel, input bit wr, input logic [15:0] d);
    logic [15:0] e = exp_rd(sel);
    string t = rd_tag(sel, m_ptr[2:0]);
    @(negedge clk);
    req_valid = 1; req_sel = sel; req_write = wr; req_wdata = d;
    @(negedge clk);
    req_valid = 0;
    model_apply(sel, wr, d);
    if (!wr) begin
      chk(rsp_valid == 1'b1, "R9 rsp_valid", rsp_valid, 1);
      chk(rsp_rdata == e, {t, " read data"}, rsp_rdata, e);
    end
    check_all(t);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    fails++;
    $display("FAIL watchdog actual=running expected=done");
    $display("  == %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

  initial begin
    logic [15:0] held;
    void'($urandom(32'd4242));
    model_reset();
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // R1 reset state
    check_all("R1");
    chk(req_ready == 1'b1, "R1 req_ready", req_ready, 1);
    acc(0, 0, 0);
    // R3 R7: bank 0 burst with auto-step, full sweep and wrap
    acc(0, 1, 16'h0080);
    acc(1, 1, 16'h01F8);
    acc(1, 1, 16'h00FF);
    acc(1, 1, 16'h00A5);
    acc(1, 1, 16'h0082);
    acc(1, 1, 16'h03FE);
    acc(1, 1, 16'h0009);
    acc(1, 1, 16'h0000);
    acc(0, 0, 0);            // R7 index wrapped to 0
    for (int k = 0; k < 7; k++) acc(1, 0, 0);
    acc(0, 0, 0);
    // R6 clear pulse on bank 1, then no stored bit
    acc(0, 1, 16'h000B);
    acc(1, 1, 16'h00D3);
    acc(1, 0, 0);
    // R8 index 7 ignored
    acc(0, 1, 16'h008F);
    acc(1, 1, 16'hFFFF);
    acc(1, 0, 0);
    acc(0, 0, 0);
    // R2 bit5 hidden on read
    acc(0, 1, 16'h0077);
    acc(0, 0, 0);
    // R9 back-pressure: stalled result holds, new request waits
    acc(0, 1, 16'h0050);
    @(negedge clk);
    rsp_ready = 0;
    req_valid = 1; req_sel = 1; req_write = 0;
    @(negedge clk);
    req_valid = 0;
    held = exp_rd(1);
    model_apply(1, 0, 0);
    chk(rsp_valid == 1'b1 && rsp_rdata == held, "R9 stalled data", rsp_rdata, held);
    req_valid = 1; req_sel = 0; req_write = 1; req_wdata = 16'h00FF;
    for (int k = 0; k < 3; k++) begin
      @(negedge clk);
      chk(req_ready == 1'b0, "R9 req_ready low", req_ready, 0);
      chk(rsp_rdata == held && rsp_valid, "R9 hold", rsp_rdata, held);
      chk(posted_wait_o == m_ptr[6], "R9 stalled write not taken", posted_wait_o, m_ptr[6]);
    end
    rsp_ready = 1;
    @(negedge clk);
    req_valid = 0;
    model_apply(0, 1, 16'h00FF);
    chk(rsp_valid == 1'b0, "R9 drained", rsp_valid, 0);
    check_all("R9");
    // random mix
    for (int n = 0; n < 600; n++) begin
      bit s = $urandom_range(0, 3) != 0;
      bit w = $urandom_range(0, 1);
      logic [15:0] d = 16'($urandom);
      acc(s, w, d);
    end
    @(negedge clk);
    $display("  == %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end
endmodule